// File: doc/BRIEF.md
# Page Write Controller with Toggle-Bit Completion Polling

This block is a bus master that programs one page of a byte-wide parallel EEPROM. On a start request it checks that the page base address is aligned to the page size. It then issues a keyed three-write unlock sequence and switches the bank-select lines to the requested bank. Next it pulls one byte per request from a local source port and writes the page's bytes to consecutive addresses.

Once the page is loaded, the controller stays off the bus for a fixed settling gap. It then reads the page's first address over and over, watching only data bit 6. The device flips that bit on every read while its internal write cycle runs. The write counts as finished when two reads in a row return the same bit 6. If the number of comparisons reaches a limit without a match, the controller stops and reports a timeout. Completion is signalled by a one-cycle done pulse, with two error flags that stay valid until the next start.

A misaligned base address is refused at once and causes no bus transaction. The bus outputs are registered, and each transaction is exactly one cycle wide. A poll read returns its data in the same cycle as its strobe.

Top module: `pageWriteCtl`

## Requirements
- R1: After reset, busy, done, busWrEn, busRdEn, srcReq, errTimeout and errAlign are 0 and bankSel is 0.
- R2: A start with a base whose low log2(PAGE_BYTES) bits are not all zero gives done=1 with errAlign=1 in the cycle after start, and no bus transaction follows.
- R3: An accepted start first produces three write transactions in consecutive cycles: 0xAA to 0x5555 with bankSel=1, then 0x55 to 0x2AAA with bankSel=0, then 0xA0 to 0x5555 with bankSel=1.
- R4: After the unlock writes come exactly PAGE_BYTES data writes. Byte i goes to address base+i, carries source byte i, and is written with bankSel equal to the requested bank number.
- R5: srcReq is high only while the controller waits for a byte, and srcIdx gives the index of that byte. A byte is taken only in a cycle where srcReq and srcValid are both 1. While srcValid stays 0, no data write is issued.
- R6: After the last data write, more than WAIT_CYCLES cycles pass with no bus transaction before the first poll read.
- R7: Poll reads go to the page base address with bankSel equal to the requested bank. Only bit 6 of busRdData is used. When two consecutive reads return equal bit 6 values, polling stops and done pulses with both error flags 0.
- R8: If POLL_LIMIT comparisons after the first read all differ, polling stops after POLL_LIMIT+1 reads in total, and done pulses with errTimeout=1.
- R9: done is high for exactly one cycle. errTimeout and errAlign keep their values until the next accepted start. A start that arrives while busy is ignored.
- R10: busWrEn and busRdEn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page program (sampled while idle) |
| pageBase | input | ADDR_W | First destination address of the page |
| bankNum | input | BANK_W | Bank to select for the data load and the polling |
| srcReq | output | 1 | Requesting the byte at srcIdx |
| srcIdx | output | log2(PAGE_BYTES) | Index of the requested byte |
| srcData | input | 8 | Source byte |
| srcValid | input | 1 | srcData holds the requested byte |
| busAddr | output | ADDR_W | Bus address |
| busWrData | output | 8 | Bus write data |
| busWrEn | output | 1 | One-cycle write strobe |
| busRdEn | output | 1 | One-cycle read strobe |
| busRdData | input | 8 | Read data, valid in the cycle busRdEn is high |
| bankSel | output | BANK_W | Bank-select lines |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| errTimeout | output | 1 | Polling hit the comparison limit |
| errAlign | output | 1 | Base address was not page aligned |

## Verification
The assertions check, on every cycle, that reads and writes never overlap, that done lasts one cycle, that a data write always carries a byte taken from the source, that a request only appears while busy, and that a refused start goes straight from idle to done. The bench scenarios are what show the exact order and contents of the unlock and data transactions, the source stalls being respected, the quiet gap before polling, and the point where polling stops. They also cover the boundary between finishing on the last allowed comparison and timing out one comparison later.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
  localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_BYTE_0  = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_1  = 8'h55;
  localparam logic [7:0]  KEY_BYTE_2  = 8'hA0;
  localparam int          POLL_BIT    = 6;

  typedef struct packed {
    logic       clrAll;
    logic       ulWr;
    logic [1:0] ulStep;
    logic       capture;
    logic       dataWr;
    logic       waitTick;
    logic       pollRd;
    logic       setAlign;
    logic       setTimeout;
  } ctlStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_KEY0, ST_KEY1, ST_KEY2, ST_LOAD, ST_WRITE,
    ST_SETTLE, ST_PREQ, ST_PBUS, ST_PEVAL, ST_FIN
  } ctlState_t;

endpackage

// File: rtl/pwcDatapath.sv
module pwcDatapath
  import pwc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          BANK_W      = 4,
  parameter int          PAGE_BYTES  = 128,
  parameter int          WAIT_CYCLES = 16,
  parameter int unsigned POLL_LIMIT  = 32'h07FF_FFFF,
  localparam int         IDX_W       = $clog2(PAGE_BYTES),
  localparam int         WAIT_W      = $clog2(WAIT_CYCLES + 1),
  localparam int         CNT_W       = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] startBase,
  input  logic [BANK_W-1:0] startBank,
  input  logic [7:0]        srcData,
  input  logic [7:0]        busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [BANK_W-1:0] bankSel,
  output logic [IDX_W-1:0]  srcIdx,
  output logic              baseAligned,
  output logic              lastByte,
  output logic              waitZero,
  output logic              pollSame,
  output logic              pollExhausted,
  output logic              errAlign,
  output logic              errTimeout
);

  logic [ADDR_W-1:0] baseQ;
  logic [BANK_W-1:0] bankQ;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        byteQ;
  logic              byteFull;
  logic [WAIT_W-1:0] waitCnt;
  logic              havePrev;
  logic              prevBit;
  logic [CNT_W-1:0]  cmpCnt;
  logic              sampleBit;

  assign sampleBit     = busRdData[POLL_BIT];
  assign baseAligned   = (startBase[IDX_W-1:0] == '0);
  assign lastByte      = (idx == IDX_W'(PAGE_BYTES - 1));
  assign waitZero      = (waitCnt == '0);
  assign pollExhausted = (cmpCnt == CNT_W'(POLL_LIMIT));
  assign srcIdx        = idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      bankQ      <= '0;
      idx        <= '0;
      byteQ      <= '0;
      byteFull   <= 1'b0;
      waitCnt    <= '0;
      havePrev   <= 1'b0;
      prevBit    <= 1'b0;
      pollSame   <= 1'b0;
      cmpCnt     <= '0;
      busAddr    <= '0;
      busWrData  <= '0;
      busWrEn    <= 1'b0;
      busRdEn    <= 1'b0;
      bankSel    <= '0;
      errAlign   <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      busWrEn <= 1'b0;
      busRdEn <= 1'b0;

      if (strb.clrAll) begin
        baseQ      <= startBase;
        bankQ      <= startBank;
        idx        <= '0;
        byteFull   <= 1'b0;
        waitCnt    <= WAIT_W'(WAIT_CYCLES);
        havePrev   <= 1'b0;
        pollSame   <= 1'b0;
        cmpCnt     <= '0;
        bankSel    <= '0;
        errAlign   <= 1'b0;
        errTimeout <= 1'b0;
      end

      if (strb.ulWr) begin
        busWrEn <= 1'b1;
        unique case (strb.ulStep)
          2'd0: begin
            busAddr   <= ADDR_W'(KEY_ADDR_HI);
            busWrData <= KEY_BYTE_0;
            bankSel   <= BANK_W'(1);
          end
          2'd1: begin
            busAddr   <= ADDR_W'(KEY_ADDR_LO);
            busWrData <= KEY_BYTE_1;
            bankSel   <= '0;
          end
          default: begin
            busAddr   <= ADDR_W'(KEY_ADDR_HI);
            busWrData <= KEY_BYTE_2;
            bankSel   <= BANK_W'(1);
          end
        endcase
      end

      if (strb.capture) begin
        byteQ    <= srcData;
        byteFull <= 1'b1;
      end

      if (strb.dataWr) begin
        busWrEn   <= 1'b1;
        busAddr   <= baseQ + ADDR_W'(idx);
        busWrData <= byteQ;
        bankSel   <= bankQ;
        idx       <= idx + 1'b1;
        byteFull  <= 1'b0;
      end

      if (strb.waitTick && !waitZero) waitCnt <= waitCnt - 1'b1;

      if (strb.pollRd) begin
        busRdEn <= 1'b1;
        busAddr <= baseQ;
      end

      if (busRdEn) begin
        prevBit  <= sampleBit;
        havePrev <= 1'b1;
        if (havePrev) begin
          pollSame <= (sampleBit == prevBit);
          cmpCnt   <= cmpCnt + 1'b1;
        end
      end

      if (strb.setAlign)   errAlign   <= 1'b1;
      if (strb.setTimeout) errTimeout <= 1'b1;
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));

  assert_write_has_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |-> byteFull);

  assert_poll_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && havePrev |-> !pollExhausted);

endmodule

// File: rtl/pwcControl.sv
module pwcControl
  import pwc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       srcValid,
  input  logic       baseAligned,
  input  logic       lastByte,
  input  logic       waitZero,
  input  logic       pollSame,
  input  logic       pollExhausted,
  output ctlStrobe_t strb,
  output logic       srcReq,
  output logic       busy,
  output logic       done
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    srcReq    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clrAll = 1'b1;
          if (!baseAligned) begin
            strb.setAlign = 1'b1;
            stateNext     = ST_FIN;
          end else begin
            stateNext = ST_KEY0;
          end
        end
      end
      ST_KEY0: begin
        strb.ulWr   = 1'b1;
        strb.ulStep = 2'd0;
        stateNext   = ST_KEY1;
      end
      ST_KEY1: begin
        strb.ulWr   = 1'b1;
        strb.ulStep = 2'd1;
        stateNext   = ST_KEY2;
      end
      ST_KEY2: begin
        strb.ulWr   = 1'b1;
        strb.ulStep = 2'd2;
        stateNext   = ST_LOAD;
      end
      ST_LOAD: begin
        srcReq = 1'b1;
        if (srcValid) begin
          strb.capture = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.dataWr = 1'b1;
        stateNext   = lastByte ? ST_SETTLE : ST_LOAD;
      end
      ST_SETTLE: begin
        strb.waitTick = 1'b1;
        if (waitZero) stateNext = ST_PREQ;
      end
      ST_PREQ: begin
        strb.pollRd = 1'b1;
        stateNext   = ST_PBUS;
      end
      ST_PBUS: stateNext = ST_PEVAL;
      ST_PEVAL: begin
        if (pollSame) begin
          stateNext = ST_FIN;
        end else if (pollExhausted) begin
          strb.setTimeout = 1'b1;
          stateNext       = ST_FIN;
        end else begin
          stateNext = ST_PREQ;
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_req_while_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    srcReq |-> busy);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done && start |=> busy);

endmodule

// File: rtl/pageWriteCtl.sv
module pageWriteCtl
  import pwc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          BANK_W      = 4,
  parameter int          PAGE_BYTES  = 128,
  parameter int          WAIT_CYCLES = 16,
  parameter int unsigned POLL_LIMIT  = 32'h07FF_FFFF,
  localparam int         IDX_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] pageBase,
  input  logic [BANK_W-1:0] bankNum,
  output logic              srcReq,
  output logic [IDX_W-1:0]  srcIdx,
  input  logic [7:0]        srcData,
  input  logic              srcValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              busWrEn,
  output logic              busRdEn,
  input  logic [7:0]        busRdData,
  output logic [BANK_W-1:0] bankSel,
  output logic              busy,
  output logic              done,
  output logic              errTimeout,
  output logic              errAlign
);

  ctlStrobe_t strb;
  logic baseAligned, lastByte, waitZero, pollSame, pollExhausted;

  pwcControl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .srcValid(srcValid),
    .baseAligned(baseAligned), .lastByte(lastByte), .waitZero(waitZero),
    .pollSame(pollSame), .pollExhausted(pollExhausted),
    .strb(strb), .srcReq(srcReq), .busy(busy), .done(done)
  );

  pwcDatapath #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_BYTES(PAGE_BYTES),
    .WAIT_CYCLES(WAIT_CYCLES), .POLL_LIMIT(POLL_LIMIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startBase(pageBase),
    .startBank(bankNum), .srcData(srcData), .busRdData(busRdData),
    .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .bankSel(bankSel), .srcIdx(srcIdx),
    .baseAligned(baseAligned), .lastByte(lastByte), .waitZero(waitZero),
    .pollSame(pollSame), .pollExhausted(pollExhausted),
    .errAlign(errAlign), .errTimeout(errTimeout)
  );

  assert_align_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && errAlign |-> !$past(busy) && !busWrEn && !busRdEn);

endmodule

// File: tb/pageWriteCtl_test.sv
module pageWriteCtl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int BANK_W     = 4;
  localparam int PAGE       = 128;
  localparam int WAITC      = 4;
  localparam int LIMIT      = 6;
  localparam int IDX_W      = $clog2(PAGE);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] pageBase = '0;
  logic [BANK_W-1:0] bankNum = '0;
  logic srcReq;
  logic [IDX_W-1:0] srcIdx;
  logic [7:0] srcData;
  logic srcValid = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWrData;
  logic busWrEn, busRdEn;
  logic [7:0] busRdData;
  logic [BANK_W-1:0] bankSel;
  logic busy, done, errTimeout, errAlign;

  pageWriteCtl #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_BYTES(PAGE),
    .WAIT_CYCLES(WAITC), .POLL_LIMIT(LIMIT)
  ) uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit          isWr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [3:0]  bank;
    string       req;
  } busItem_t;

  busItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  logic [7:0] seed = 8'h00;
  bit stallOn = 1'b0;
  int stallCtr = 0;
  int togN = 0;
  int rdIdx = 0;
  bit rdClr = 1'b0;
  int lastWrCycle = -1000;
  bit prevWasWr = 1'b0;

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 5) + s ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cycle <= cycle + 1;

  // source port model
  assign srcData = pat(int'(srcIdx), seed);
  always @(negedge clk) begin
    stallCtr <= stallCtr + 1;
    srcValid <= srcReq && (!stallOn || (stallCtr % 3 == 2));
  end

  // device read model: bit 6 toggles for reads 0..togN, then holds
  always @(posedge clk) begin
    if (rdClr) rdIdx <= 0;
    else if (busRdEn) rdIdx <= rdIdx + 1;
  end
  always_comb begin
    busRdData = 8'(rdIdx * 37) & 8'hBF;
    busRdData[6] = (rdIdx <= togN) ? rdIdx[0] : togN[0];
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      check(!(busWrEn && busRdEn), "R10", "read and write overlap",
            {busWrEn, busRdEn}, 0);
      if (busWrEn || busRdEn) begin
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected bus transaction", busAddr, 0);
        end else begin
          busItem_t e;
          e = expQ.pop_front();
          check(busWrEn == e.isWr, e.req, "transaction kind", busWrEn, e.isWr);
          check(busAddr == e.addr, e.req, "address", busAddr, e.addr);
          check(bankSel == e.bank, e.req, "bank", bankSel, e.bank);
          if (e.isWr) check(busWrData == e.data, e.req, "write data", busWrData, e.data);
        end
        if (busRdEn && prevWasWr)
          check(cycle - lastWrCycle > WAITC, "R6", "gap before first poll",
                cycle - lastWrCycle, WAITC + 1);
        if (busWrEn) lastWrCycle = cycle;
        prevWasWr = busWrEn;
      end
    end
  end

  task automatic runOp(input logic [15:0] base, input logic [3:0] bank,
                       input logic [7:0] s, input int toggles, input bit stall,
                       input bit pokeStart);
    bit aligned = (base[6:0] == 0);
    bit expTo = (toggles + 1 > LIMIT);
    int nRd = expTo ? LIMIT + 1 : toggles + 2;
    int wd = 0;
    @(negedge clk);
    seed = s; stallOn = stall; togN = toggles; rdClr = 1'b1;
    if (aligned) begin
      expQ.push_back('{1, 16'h5555, 8'hAA, 4'h1, "R3"});
      expQ.push_back('{1, 16'h2AAA, 8'h55, 4'h0, "R3"});
      expQ.push_back('{1, 16'h5555, 8'hA0, 4'h1, "R3"});
      for (int i = 0; i < PAGE; i++)
        expQ.push_back('{1, base + 16'(i), pat(i, s), bank, "R4"});
      for (int i = 0; i < nRd; i++)
        expQ.push_back('{0, base, 8'h00, bank, expTo ? "R8" : "R7"});
    end
    pageBase = base; bankNum = bank; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rdClr = 1'b0;
    if (!aligned)
      check(done && errAlign, "R2", "refused start done+errAlign", {done, errAlign}, 2'b11);
    if (pokeStart) begin
      repeat (40) @(negedge clk);
      pageBase = base ^ 16'h0400; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wd < 5000) begin @(negedge clk); wd++; end
    check(done == 1'b1, "R9", "done seen", done, 1);
    check(errTimeout == (aligned && expTo), expTo ? "R8" : "R7", "errTimeout",
          errTimeout, aligned && expTo);
    check(errAlign == !aligned, "R2", "errAlign", errAlign, !aligned);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
    check(errTimeout == (aligned && expTo) && errAlign == !aligned, "R9",
          "flags held", {errTimeout, errAlign}, {aligned && expTo, !aligned});
    check(busy == 1'b0, "R9", "idle after done", busy, 0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4", "all expected transactions seen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !busWrEn && !busRdEn && !srcReq && !errTimeout &&
          !errAlign && bankSel == 0, "R1", "reset state",
          {busy, done, busWrEn, busRdEn, srcReq, errTimeout, errAlign, bankSel}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runOp(16'h0100, 4'h3, 8'h11, 3, 1'b0, 1'b0);   // R3 R4 R7 basic
    runOp(16'h7F80, 4'hA, 8'h5A, 0, 1'b1, 1'b0);   // R5 stalls, R7 immediate match
    runOp(16'h0080, 4'h5, 8'h77, LIMIT, 1'b0, 1'b0); // R8 one past the limit
    runOp(16'h0200, 4'h1, 8'hC3, LIMIT - 1, 1'b1, 1'b1); // R7 last comparison, R9 start ignored
    runOp(16'h0141, 4'h2, 8'h00, 0, 1'b0, 1'b0);   // R2 misaligned
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule